// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is a single pulse-width-modulation timer channel. A down counter runs through one period, and a comparator holds the output pin active while the counter value is at or below the active compare value. Software programs the period and the duty through two buffer registers. It can write them at any moment, and they do not disturb the running waveform. The buffered values reach the live counter and comparator only when software pulses a manual-update control or when the counter wraps with autoreload enabled.

A single write port reaches three targets: the count buffer, the compare buffer and a small control register. The control register holds start, manual update, output invert and autoreload. The counter only advances on cycles where the external tick enable is high, so a shared prescaler can pace several channels. A period of N+1 ticks and a high time of C+1 ticks are programmed as count N and compare C. An all-ones compare value keeps the pin continuously active. When the active compare is all-ones, any write to a buffer forces a reload. This stops a disabled channel from sticking high.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: The write port selects its target with wr_sel: code 0 is the count buffer, code 1 is the compare buffer, code 2 is the control register and code 3 is ignored. Control bits are start at bit 0, manual update at bit 1, invert at bit 2 and autoreload at bit 3.
- R2: After reset the buffers and the active counter and compare are zero. The control register holds invert=1 with every other bit 0, so the pin idles low.
- R3: The counter decrements by one on each clock where start is set, the channel is not stopped and tick is high. It holds its value when tick or start is low. With start low the pin shows its inactive level.
- R4: With count N and compare C loaded and autoreload set, each period lasts N+1 ticks. The un-inverted level is active for exactly the C+1 ticks where the counter is at or below C.
- R5: An all-ones compare keeps the level active on every cycle of the period. The smallest compare value (0) still gives one active tick per period, so a zero duty cycle is not produced.
- R6: While the manual-update bit is set, both buffers are copied into the active counter and compare register on every clock. This copy also clears a stopped state.
- R7: A buffer write does not change the active counter or compare value until a manual update, a forced reload or an autoreload.
- R8: With autoreload set, a counter at zero reloads from both buffers on the next tick. With autoreload clear, the period in progress completes, and then the channel stops with the pin inactive.
- R9: With invert=1 the pin equals the comparator level. With invert=0 the pin is the complement of that level, so a stopped channel drives the pin high.
- R10: If the active compare is all-ones when a count or compare buffer write takes effect, both buffers are loaded into the active registers on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one clock |
| wr_sel | input | 2 | Write target: 0 count buffer, 1 compare buffer, 2 control |
| wr_data | input | CNT_W | Write data; control uses bits 3:0 |
| tick | input | 1 | Per-clock enable that paces the counter |
| pwm_out | output | 1 | PWM pin after polarity selection |

## Verification
The hardest situation to reach from the ports is a forced reload. It needs a running channel whose live compare is all-ones, and then a buffer write in the middle of a period. The bench starts the channel at 100% duty with a long period, writes a small compare value and checks the exact cycle-by-cycle pin pattern. The pin must fall in the same period, which would not happen if it had to wait for autoreload. The other awkward cases are handled the same way. Aligning control writes to the cycle right after a manual load makes the partial period after an autoreload clear deterministic. A buffer write made while start is low shows that the frozen counter resumes with the old compare before the new one takes over.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_CONTROL = 2'd2
  } wr_sel_e;

  // packed: reload is bit 3, invert bit 2, manual bit 1, start bit 0
  typedef struct packed {
    logic reload;
    logic invert;
    logic manual;
    logic start;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam ctl_t CTL_RESET = '{reload: 1'b0, invert: 1'b1, manual: 1'b0, start: 1'b0};

endpackage

// File: rtl/pwm_dbuf_rstsync.sv
module pwm_dbuf_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cmp_full,
  output logic [CNT_W-1:0] cnt_buf,
  output logic [CNT_W-1:0] cmp_buf,
  output ctl_t             ctl,
  output logic             force_load
);
  logic             cnt_en, cmp_en, ctl_en, buf_write;
  logic             force_d;
  logic [CNT_W-1:0] cnt_buf_q, cmp_buf_q;
  ctl_t             ctl_q;
  logic             force_q;

  always_comb begin
    cnt_en    = wr_en && (wr_sel == SEL_COUNT);
    cmp_en    = wr_en && (wr_sel == SEL_COMPARE);
    ctl_en    = wr_en && (wr_sel == SEL_CONTROL);
    buf_write = cnt_en || cmp_en;
    // a buffer write while the live compare is all-ones must reload
    force_d   = buf_write && cmp_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_buf_q <= '0;
      cmp_buf_q <= '0;
      ctl_q     <= CTL_RESET;
      force_q   <= 1'b0;
    end else begin
      if (cnt_en) cnt_buf_q <= wr_data;
      if (cmp_en) cmp_buf_q <= wr_data;
      if (ctl_en) ctl_q     <= ctl_t'(wr_data[CTL_W-1:0]);
      force_q <= force_d;
    end
  end

  assign cnt_buf    = cnt_buf_q;
  assign cmp_buf    = cmp_buf_q;
  assign ctl        = ctl_q;
  assign force_load = force_q;

  // R7: buffers only move on a write strobe aimed at them
  a_r7_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cnt_buf_q) && $stable(cmp_buf_q)));
endmodule

// File: rtl/pwm_dbuf_core.sv
module pwm_dbuf_core
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  ctl_t             ctl,
  input  logic             force_load,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic             running,
  output logic             level,
  output logic             cmp_full,
  output logic [CNT_W-1:0] cmp_act
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cmp_q, cmp_d;
  logic             done_q, done_d;
  logic             load, advance, at_zero;

  always_comb begin
    load    = ctl.manual || force_load;
    advance = tick && ctl.start && !done_q;
    at_zero = (cnt_q == '0);
    cnt_d   = cnt_q;
    cmp_d   = cmp_q;
    done_d  = done_q;
    if (load) begin
      cnt_d  = cnt_buf;
      cmp_d  = cmp_buf;
      done_d = 1'b0;
    end else if (advance) begin
      if (!at_zero) begin
        cnt_d = cnt_q - ONE;
      end else if (ctl.reload) begin
        cnt_d = cnt_buf;
        cmp_d = cmp_buf;
      end else begin
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
      done_q <= done_d;
    end
  end

  assign running  = ctl.start && !done_q;
  assign level    = running && (cnt_q <= cmp_q);
  assign cmp_full = (cmp_q == ALL_ONES);
  assign cmp_act  = cmp_q;

  // R6: a manual update copies both buffers
  a_r6_manual_copy: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.manual |=> (cnt_q == $past(cnt_buf) && cmp_q == $past(cmp_buf) && !done_q));
  // R3: no tick or no start means the counter holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (!tick || !ctl.start)) |=> $stable(cnt_q));
  // R3: a qualifying tick above zero decrements by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
  // R8: a stopped channel stays stopped until a load
  a_r8_stay_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !load) |=> (done_q && $stable(cnt_q)));
  // R8: autoreload at zero copies both buffers
  a_r8_autoreload: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance && cnt_q == '0 && ctl.reload) |=>
      (cnt_q == $past(cnt_buf) && cmp_q == $past(cmp_buf)));
endmodule

// File: rtl/pwm_dbuf_outpol.sv
module pwm_dbuf_outpol (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic running,
  input  logic invert,
  output logic pin
);
  always_comb begin
    pin = invert ? level : !level;
  end

  // R9: a stopped or frozen channel shows the inactive level of its polarity
  a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pin == !invert));
endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W       = 32, // 32 or 16
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  output logic             pwm_out
);
  logic             rst_i_n;
  logic [CNT_W-1:0] cnt_buf, cmp_buf, cmp_act;
  ctl_t             ctl;
  logic             force_load, cmp_full, running, level;

  pwm_dbuf_rstsync #(.STAGES(SYNC_STAGES)) i_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pwm_dbuf_regs #(.CNT_W(CNT_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .cmp_full   (cmp_full),
    .cnt_buf    (cnt_buf),
    .cmp_buf    (cmp_buf),
    .ctl        (ctl),
    .force_load (force_load)
  );

  pwm_dbuf_core #(.CNT_W(CNT_W)) i_core (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .tick       (tick),
    .ctl        (ctl),
    .force_load (force_load),
    .cnt_buf    (cnt_buf),
    .cmp_buf    (cmp_buf),
    .running    (running),
    .level      (level),
    .cmp_full   (cmp_full),
    .cmp_act    (cmp_act)
  );

  pwm_dbuf_outpol i_outpol (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .level   (level),
    .running (running),
    .invert  (ctl.invert),
    .pin     (pwm_out)
  );

  // R10: a buffer write seen with an all-ones live compare reloads one clock later
  a_r10_forced_reload: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_en && (wr_sel == SEL_COUNT || wr_sel == SEL_COMPARE) && cmp_full)
      |=> ##1 (cmp_act == $past(cmp_buf)));
endmodule

// File: tb/test_pwm_dbuf_channel.sv
`timescale 1ns/1ps
module test_pwm_dbuf_channel;
  localparam int W = 32;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [1:0]   wr_sel;
  logic [W-1:0] wr_data;
  logic         tick;
  logic         pwm_out;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwm_dbuf_channel #(.CNT_W(W)) i_pwm_dbuf_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick(tick), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] sel, input logic [W-1:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic smp(output logic v);
    v = pwm_out;
    @(negedge clk);
  endtask

  // manual update with start clear, then start+autoreload, invert kept
  task automatic start_seq(input logic [W-1:0] n, input logic [W-1:0] c);
    wr(2'd0, n);
    wr(2'd1, c);
    wr(2'd2, 32'd6);
    wr(2'd2, 32'd13);
  endtask

  task automatic measure(input string req, input int n, input int c, input int m,
                         input int exp_high, input int exp_rise);
    int   high = 0, rise = 0;
    logic prev, v;
    prev = pwm_out;
    for (int i = 0; i < m * (n + 1); i++) begin
      smp(v);
      if (v) high++;
      if (v && !prev) rise++;
      prev = v;
    end
    chk({req, " active ticks"}, high, exp_high);
    chk({req, " periods"}, rise, exp_rise);
  endtask

  task automatic t_reset;
    logic v;
    smp(v);
    chk("R2 reset pin idle low", v, 0);
    wr(2'd0, 32'd5);
    wr(2'd3, 32'hF);   // code 3 ignored, control must stay at reset value
    smp(v);
    chk("R1 code 3 ignored, R3 stopped pin low", v, 0);
  endtask

  task automatic t_duty;
    start_seq(32'd3, 32'd1);
    measure("R4 N=3 C=1", 3, 1, 4, 8, 4);
    start_seq(32'd9, 32'd0);
    measure("R5 compare 0 one tick", 9, 0, 3, 3, 3);
    start_seq(32'd4, ONES);
    measure("R5 all-ones full duty", 4, 4, 3, 15, 0);
  endtask

  task automatic t_tick_gate;
    int   high = 0;
    logic v;
    start_seq(32'd3, 32'd1);
    for (int i = 0; i < 2 * 3 * 4; i++) begin
      tick = i[0];
      smp(v);
      if (v) high++;
    end
    tick = 1'b1;
    chk("R3 half-rate tick doubles period", high, 12);
  endtask

  task automatic t_freeze_buffer;
    logic v;
    int   exp_v [15] = '{0,0,0,1,1,1,1,0,0,0,0,0,0,0,1};
    start_seq(32'd7, 32'd3);
    wr(2'd2, 32'd12);          // start low, counter freezes at 6
    for (int i = 0; i < 10; i++) begin
      smp(v);
      if (i == 9) chk("R3 start low pin inactive", v, 0);
    end
    wr(2'd1, 32'd0);           // new compare only buffered
    wr(2'd2, 32'd13);          // resume
    for (int i = 0; i < 15; i++) begin
      smp(v);
      chk($sformatf("R7 frozen resume old compare then new, sample %0d", i), v, exp_v[i]);
    end
  endtask

  task automatic t_autoreload_clear;
    int   high = 0;
    logic v;
    start_seq(32'd7, 32'd3);
    wr(2'd2, 32'd5);           // autoreload off: finish this period then stop
    for (int i = 0; i < 16; i++) begin
      smp(v);
      if (v) high++;
    end
    chk("R8 period completes after autoreload clear", high, 4);
    chk("R8 stopped pin inactive", v, 0);
    start_seq(32'd3, 32'd2);   // manual update restarts a stopped channel
    measure("R6 restart after stop", 3, 2, 2, 6, 2);
  endtask

  task automatic t_invert;
    logic v;
    start_seq(32'd3, 32'd1);
    wr(2'd2, 32'd9);           // invert off
    measure("R9 inverted level", 3, 1, 4, 8, 4);
    wr(2'd2, 32'd8);           // stop, invert off
    smp(v);
    chk("R9 stopped pin high when invert clear", v, 1);
    wr(2'd2, 32'd4);
  endtask

  task automatic t_forced;
    logic v;
    int   exp_v [9] = '{0,0,0,0,0,0,1,1,0};
    start_seq(32'd7, ONES);
    wr(2'd1, 32'd1);
    smp(v);
    chk("R10 still full before forced reload", v, 1);
    for (int i = 0; i < 9; i++) begin
      smp(v);
      chk($sformatf("R10 forced reload pattern, sample %0d", i), v, exp_v[i]);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; tick = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_duty();
    t_tick_gate();
    t_freeze_buffer();
    t_autoreload_clear();
    t_invert();
    t_forced();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule